// File: doc/BRIEF.md
# Host Control Line Conditioner and Edge Event Register

This block takes four asynchronous control lines from a host (select-in, strobe, auto-feed and init) into the local clock domain. Each line passes through a two-flop synchronizer and then a glitch filter. A single control input switches the filter on for all four lines together. The conditioned levels appear as status outputs. Every rising and falling transition of a conditioned level sets its own sticky event flag.

Three further single-cycle inputs report a received data byte, a received command byte and an invalid transfer termination. Each one sets a sticky flag of its own. All eleven flags sit in one event register. An enable register with the same bit layout decides which flags may drive a single registered interrupt line. A simple write port clears event flags by writing ones, and it also loads the enable register.

A driver services the port by reading the event register, handling the flags it finds, and writing those same bits back to clear them.

Top module: `hctl_event_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `evt_q`, `en_q`, `level_q` and `irq` are all zero.
- R2: With `filt_en` low, a change on `host_in[i]` that is first sampled at clock edge k appears on `level_q[i]` after edge k+2. A one-cycle pulse on the input passes through.
- R3: With `filt_en` high, `level_q[i]` takes a new value only after the synchronized line has held that value on 3 consecutive clock edges. A change first sampled at edge k appears after edge k+4. A pulse of 2 cycles or less is ignored.
- R4: Line index i is mapped as 0 = select-in, 1 = strobe, 2 = auto-feed, 3 = init. A rising `level_q[i]` sets event bit 2*i, and a falling `level_q[i]` sets event bit 2*i+1, one edge after the level changes.
- R5: A high `data_evt` sets event bit 8, a high `cmd_evt` sets bit 9, and a high `bad_term_evt` sets bit 10, each at the clock edge that samples the input.
- R6: Event bits are sticky. A write with `wr_en`=1 and `wr_sel`=0 clears every event bit where `wr_data` holds a 1 and leaves the other bits unchanged. Writes with `wr_sel`=1 leave the event bits unchanged.
- R7: If a set condition and a clear write hit the same event bit in the same cycle, the bit ends up set.
- R8: A write with `wr_en`=1 and `wr_sel`=1 loads `wr_data[10:0]` into the enable register, which uses the same bit layout as the event register. Bits 15 to 11 of `evt_q` and `en_q` always read zero.
- R9: `irq` is registered. It goes high one edge after some event bit and its enable bit are both 1, and it goes low one edge after no such pair remains. Events whose enable bit is 0 never raise it.
- R10: `filt_en` applies to all four lines at once. Simultaneous changes on every line are delayed by the same amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| host_in | input | 4 | Raw asynchronous host control lines, index per R4 |
| filt_en | input | 1 | Switches the glitch filter on for all lines |
| data_evt | input | 1 | Pulse: data byte received |
| cmd_evt | input | 1 | Pulse: command byte received |
| bad_term_evt | input | 1 | Pulse: invalid termination detected |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 = clear events by writing ones, 1 = load enables |
| wr_data | input | 16 | Write data |
| level_q | output | 4 | Conditioned host line levels |
| evt_q | output | 16 | Sticky event register |
| en_q | output | 16 | Interrupt enable register |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench counts the exact edge at which each level and event flag first shows a change, in both filter modes. A latency that is off by one, whether from a missing synchronizer stage or a filter that accepts one edge early, therefore fails a check. It sends a two-cycle strobe glitch with the filter on, where a filter that is too short would pass the glitch and post events. It also sends a one-cycle pulse with the filter off, where a filter that does not switch off would swallow the pulse. Further checks cover a clear that lands in the same cycle as a new data event, where a design that gives the clear priority loses the event, and a disabled command event, where a wrong enable mask would raise the interrupt.

// File: rtl/hctl_pkg.sv
package hctl_pkg;
   // Write target select values on the register port
   typedef enum logic {
      WSEL_EVT_CLR = 1'b0,
      WSEL_ENABLE  = 1'b1
   } wsel_e;

   // Event register width: a rise/fall pair per line plus three message events
   function automatic int evt_width(input int lines);
      return 2 * lines + 3;
   endfunction
endpackage

// File: rtl/hctl_sync.sv
module hctl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/hctl_level_filter.sv
module hctl_level_filter #(
   parameter int FILT_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic filt_en,
   input  logic din,
   output logic level
);
   localparam int CNT_W = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

   logic [CNT_W-1:0] run_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level   <= 1'b0;
         run_cnt <= '0;
      end else if (!filt_en) begin
         level   <= din;
         run_cnt <= '0;
      end else if (din == level) begin
         run_cnt <= '0;
      end else if (run_cnt == CNT_LAST) begin
         level   <= din;
         run_cnt <= '0;
      end else begin
         run_cnt <= run_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/hctl_evt_bank.sv
module hctl_evt_bank
   import hctl_pkg::*;
#(
   parameter int NUM_LINES = 4,
   parameter int REG_W     = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] level,
   input  logic                 data_evt,
   input  logic                 cmd_evt,
   input  logic                 bad_term_evt,
   input  logic                 wr_en,
   input  logic                 wr_sel,
   input  logic [REG_W-1:0]     wr_data,
   output logic [REG_W-1:0]     evt_q,
   output logic [REG_W-1:0]     en_q,
   output logic                 irq
);
   localparam int EVT_W    = evt_width(NUM_LINES);
   localparam int DATA_BIT = 2 * NUM_LINES;

   logic [NUM_LINES-1:0] level_d;
   logic [EVT_W-1:0]     set_v, clr_v, evt_r, en_r;
   logic                 unused_wr_hi;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_LINES; gi++) begin : g_edge
         assign set_v[2*gi]   =  level[gi] & ~level_d[gi];
         assign set_v[2*gi+1] = ~level[gi] &  level_d[gi];
      end
   endgenerate

   assign set_v[DATA_BIT]   = data_evt;
   assign set_v[DATA_BIT+1] = cmd_evt;
   assign set_v[DATA_BIT+2] = bad_term_evt;

   assign clr_v = (wr_en && wsel_e'(wr_sel) == WSEL_EVT_CLR) ? wr_data[EVT_W-1:0] : '0;
   assign unused_wr_hi = ^wr_data[REG_W-1:EVT_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level_d <= '0;
         evt_r   <= '0;
         en_r    <= '0;
         irq     <= 1'b0;
      end else begin
         level_d <= level;
         evt_r   <= (evt_r & ~clr_v) | set_v;
         if (wr_en && wsel_e'(wr_sel) == WSEL_ENABLE)
            en_r <= wr_data[EVT_W-1:0];
         irq <= |(evt_r & en_r);
      end
   end

   assign evt_q = REG_W'(evt_r);
   assign en_q  = REG_W'(en_r);
endmodule

// File: rtl/hctl_event_unit.sv
module hctl_event_unit
   import hctl_pkg::*;
#(
   parameter int NUM_LINES      = 4,
   parameter int SYNC_STAGES    = 2,
   parameter int FILT_LEN       = 3,
   parameter int REG_W          = 16,
   parameter bit FILTER_PRESENT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] host_in,
   input  logic                 filt_en,
   input  logic                 data_evt,
   input  logic                 cmd_evt,
   input  logic                 bad_term_evt,
   input  logic                 wr_en,
   input  logic                 wr_sel,
   input  logic [REG_W-1:0]     wr_data,
   output logic [NUM_LINES-1:0] level_q,
   output logic [REG_W-1:0]     evt_q,
   output logic [REG_W-1:0]     en_q,
   output logic                 irq
);
   localparam int EVT_W = evt_width(NUM_LINES);

   generate
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("hctl_event_unit: SYNC_STAGES must be at least 2");
      end
      if (FILT_LEN < 2) begin : g_chk_filt
         $error("hctl_event_unit: FILT_LEN must be at least 2");
      end
      if (REG_W <= EVT_W) begin : g_chk_regw
         $error("hctl_event_unit: REG_W must exceed the event count");
      end
   endgenerate

   logic [NUM_LINES-1:0] sync_v;

   genvar gl;
   generate
      for (gl = 0; gl < NUM_LINES; gl++) begin : g_line
         hctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (host_in[gl]),
            .dout (sync_v[gl])
         );
         if (FILTER_PRESENT) begin : g_filt
            hctl_level_filter #(.FILT_LEN(FILT_LEN)) u_filt (
               .clk    (clk),
               .rst_n  (rst_n),
               .filt_en(filt_en),
               .din    (sync_v[gl]),
               .level  (level_q[gl])
            );
         end else begin : g_nofilt
            always_ff @(posedge clk) begin
               if (!rst_n) level_q[gl] <= 1'b0;
               else        level_q[gl] <= sync_v[gl];
            end
         end
      end
   endgenerate

   hctl_evt_bank #(.NUM_LINES(NUM_LINES), .REG_W(REG_W)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .level       (level_q),
      .data_evt    (data_evt),
      .cmd_evt     (cmd_evt),
      .bad_term_evt(bad_term_evt),
      .wr_en       (wr_en),
      .wr_sel      (wr_sel),
      .wr_data     (wr_data),
      .evt_q       (evt_q),
      .en_q        (en_q),
      .irq         (irq)
   );
endmodule

// File: rtl/hctl_event_chk.sv
module hctl_event_chk #(
   parameter int NUM_LINES = 4,
   parameter int REG_W     = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] host_in,
   input logic                 data_evt,
   input logic                 cmd_evt,
   input logic                 bad_term_evt,
   input logic                 wr_en,
   input logic                 wr_sel,
   input logic [REG_W-1:0]     wr_data,
   input logic [NUM_LINES-1:0] level_q,
   input logic [REG_W-1:0]     evt_q,
   input logic [REG_W-1:0]     en_q,
   input logic                 irq
);
   localparam int EVT_W    = 2 * NUM_LINES + 3;
   localparam int DATA_BIT = 2 * NUM_LINES;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_LINES; gi++) begin : g_line_chk
         // R4: level transitions post their own event flag
         p_rise_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(level_q[gi]) |=> evt_q[2*gi]);
         p_fall_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(level_q[gi]) |=> evt_q[2*gi+1]);
         // R2: a new level always equals the input sampled three edges earlier
         p_level_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $changed(level_q[gi]) |-> (level_q[gi] == $past(host_in[gi], 3)));
      end
      for (gi = 0; gi < EVT_W; gi++) begin : g_bit_chk
         // R6: a flag stays set unless a clear write names it
         p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_q[gi] && !(wr_en && !wr_sel && wr_data[gi])) |=> evt_q[gi]);
      end
   endgenerate

   // R5 / R7: message events set their flag even against a same-cycle clear
   p_data_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      data_evt |=> evt_q[DATA_BIT]);
   p_cmd_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_evt |=> evt_q[DATA_BIT+1]);
   p_bad_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bad_term_evt |=> evt_q[DATA_BIT+2]);

   // R9: interrupt follows pending enabled events one edge later
   p_irq_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_q & en_q)) |=> irq);
   p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(|(evt_q & en_q)));
endmodule

bind hctl_event_unit hctl_event_chk #(.NUM_LINES(NUM_LINES), .REG_W(REG_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_in     (host_in),
   .data_evt    (data_evt),
   .cmd_evt     (cmd_evt),
   .bad_term_evt(bad_term_evt),
   .wr_en       (wr_en),
   .wr_sel      (wr_sel),
   .wr_data     (wr_data),
   .level_q     (level_q),
   .evt_q       (evt_q),
   .en_q        (en_q),
   .irq         (irq)
);

// File: tb/tb_hctl_event_unit.sv
`timescale 1ns/1ps
module tb_hctl_event_unit;
   localparam int KIND_EVT = 0, KIND_EN = 1, KIND_LVL = 2, KIND_IRQ = 3;

   typedef struct {
      int          cyc;
      int          kind;
      logic [15:0] val;
      string       req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  host_in = '0;
   logic        filt_en = 1'b0;
   logic        data_evt = 1'b0, cmd_evt = 1'b0, bad_term_evt = 1'b0;
   logic        wr_en = 1'b0, wr_sel = 1'b0;
   logic [15:0] wr_data = '0;
   logic [3:0]  level_q;
   logic [15:0] evt_q, en_q;
   logic        irq;

   int   cyc = 0;
   int   n_checks = 0;
   int   n_errors = 0;
   bit   done = 1'b0;
   exp_t sb_q[$];

   hctl_event_unit dut (
      .clk(clk), .rst_n(rst_n), .host_in(host_in), .filt_en(filt_en),
      .data_evt(data_evt), .cmd_evt(cmd_evt), .bad_term_evt(bad_term_evt),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .level_q(level_q), .evt_q(evt_q), .en_q(en_q), .irq(irq)
   );

   always #10 clk = ~clk;   // 50 MHz
   always @(posedge clk) cyc <= cyc + 1;

   // Driver side: queue an expected value for a cycle offset from now
   task automatic expect_at(input int dly, input int kind, input logic [15:0] v, input string req);
      exp_t e;
      e.cyc = cyc + dly; e.kind = kind; e.val = v; e.req = req;
      sb_q.push_back(e);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_write(input logic sel, input logic [15:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   // Monitor: pop and compare items due in this cycle
   always @(negedge clk) begin
      for (int i = sb_q.size() - 1; i >= 0; i--) begin
         if (sb_q[i].cyc == cyc) begin
            logic [15:0] act;
            case (sb_q[i].kind)
               KIND_EVT: act = evt_q;
               KIND_EN:  act = en_q;
               KIND_LVL: act = {12'h000, level_q};
               default:  act = {15'h0000, irq};
            endcase
            n_checks++;
            if (act !== sb_q[i].val) begin
               n_errors++;
               $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                        sb_q[i].req, sb_q[i].kind, cyc, act, sb_q[i].val);
            end
            sb_q.delete(i);
         end
      end
   end

   initial begin
      idle(4);
      // R1: reset state, checked during and right after reset
      expect_at(0, KIND_EVT, 16'h0000, "R1");
      expect_at(0, KIND_IRQ, 16'h0000, "R1");
      rst_n = 1'b1;
      expect_at(1, KIND_EVT, 16'h0000, "R1");
      expect_at(1, KIND_EN,  16'h0000, "R1");
      expect_at(1, KIND_LVL, 16'h0000, "R1");
      expect_at(1, KIND_IRQ, 16'h0000, "R1");
      idle(3);

      // R2 / R4: unfiltered strobe rise
      host_in = 4'b0010;
      expect_at(2, KIND_LVL, 16'h0000, "R2");
      expect_at(3, KIND_LVL, 16'h0002, "R2");
      expect_at(3, KIND_EVT, 16'h0000, "R4");
      expect_at(4, KIND_EVT, 16'h0004, "R4");
      idle(6);
      // R4: strobe fall
      host_in = 4'b0000;
      expect_at(3, KIND_LVL, 16'h0000, "R2");
      expect_at(4, KIND_EVT, 16'h000C, "R4");
      idle(6);
      // R4: select-in, auto-feed, init rise together
      host_in = 4'b1101;
      expect_at(3, KIND_LVL, 16'h000D, "R2");
      expect_at(4, KIND_EVT, 16'h005D, "R4");
      idle(6);

      // R6: partial write-one-to-clear
      expect_at(1, KIND_EVT, 16'h0058, "R6");
      reg_write(1'b0, 16'h0005);
      idle(2);
      // R8: enable load, reserved bits read zero; R6: events untouched
      expect_at(1, KIND_EN,  16'h07FF, "R8");
      expect_at(1, KIND_EVT, 16'h0058, "R6");
      expect_at(1, KIND_IRQ, 16'h0000, "R9");
      expect_at(2, KIND_IRQ, 16'h0001, "R9");
      reg_write(1'b1, 16'hFFFF);
      idle(3);
      // R9: clearing all events drops irq one edge later
      expect_at(1, KIND_EVT, 16'h0000, "R6");
      expect_at(1, KIND_IRQ, 16'h0001, "R9");
      expect_at(2, KIND_IRQ, 16'h0000, "R9");
      reg_write(1'b0, 16'h07FF);
      idle(3);

      // R5 / R9: message events with only data enabled
      expect_at(1, KIND_EN, 16'h0100, "R8");
      reg_write(1'b1, 16'h0100);
      cmd_evt = 1'b1;
      expect_at(1, KIND_EVT, 16'h0200, "R5");
      expect_at(2, KIND_IRQ, 16'h0000, "R9");
      @(negedge clk); cmd_evt = 1'b0;
      idle(2);
      data_evt = 1'b1;
      expect_at(1, KIND_EVT, 16'h0300, "R5");
      expect_at(2, KIND_IRQ, 16'h0001, "R9");
      @(negedge clk); data_evt = 1'b0;
      bad_term_evt = 1'b1;
      expect_at(1, KIND_EVT, 16'h0700, "R5");
      @(negedge clk); bad_term_evt = 1'b0;
      idle(2);
      // R7: set beats clear in the same cycle
      data_evt = 1'b1;
      expect_at(1, KIND_EVT, 16'h0100, "R7");
      reg_write(1'b0, 16'h0700);
      data_evt = 1'b0;
      idle(2);
      expect_at(1, KIND_EVT, 16'h0000, "R6");
      expect_at(2, KIND_IRQ, 16'h0000, "R9");
      reg_write(1'b0, 16'h07FF);
      idle(3);

      // R3: filtered select-in fall
      filt_en = 1'b1;
      idle(2);
      host_in = 4'b1100;
      expect_at(4, KIND_LVL, 16'h000D, "R3");
      expect_at(5, KIND_LVL, 16'h000C, "R3");
      expect_at(6, KIND_EVT, 16'h0002, "R3");
      idle(8);
      // R3: two-cycle strobe glitch is rejected
      host_in = 4'b1110;
      expect_at(4, KIND_LVL, 16'h000C, "R3");
      expect_at(5, KIND_LVL, 16'h000C, "R3");
      expect_at(8, KIND_EVT, 16'h0002, "R3");
      idle(2);
      host_in = 4'b1100;
      idle(8);
      // R10: all four lines change at once, equal filtered delay
      host_in = 4'b0011;
      expect_at(4, KIND_LVL, 16'h000C, "R10");
      expect_at(5, KIND_LVL, 16'h0003, "R10");
      expect_at(6, KIND_EVT, 16'h00A7, "R10");
      idle(8);

      // R2: one-cycle auto-feed pulse passes with filter off
      filt_en = 1'b0;
      idle(2);
      host_in = 4'b0111;
      expect_at(3, KIND_LVL, 16'h0007, "R2");
      expect_at(4, KIND_LVL, 16'h0003, "R2");
      expect_at(4, KIND_EVT, 16'h00B7, "R2");
      expect_at(5, KIND_EVT, 16'h00B7, "R4");
      idle(1);
      host_in = 4'b0011;
      idle(8);

      if (sb_q.size() != 0) begin
         n_errors++;
         $display("FAIL scoreboard: %0d expected items never compared", sb_q.size());
      end
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

   // Watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end
endmodule